// File: doc/BRIEF.md
# One-Time-Lockable Security Register Bank

The block holds a small bank of security words split into two regions. The first region pairs a 64-bit identifier, loaded from a parameter at reset and never writable afterwards, with a 64-bit user area. The second region is a user area of 128 sixteen-bit words. Each region has its own lock. Once a lock is set, every later write to that region is refused.

Software writes through a two-step command port. A setup cycle selects either a program or a lock operation, and the following data cycle carries the address and the data. Writes follow flash rules: the new data is ANDed into the stored word, so a bit can only go from 1 to 0. The lock values obey the same rule, which makes them irreversible. The read port returns bank contents only while the identification mode input is high. A status query returns a lock value in any mode.

Address map in 16-bit words (default parameters): 080h first-region lock, 081h to 084h identifier (least significant word at 081h), 085h to 088h first-region user words, 089h second-region lock word, 08Ah to 109h second-region words.

Top module: `prot_reg_bank`

## Requirements
- R1: After reset, the identifier words read back the parameter value, least significant word first. Every user word reads FFFFh, both status queries return FFFFh, and prog_err and rd_valid are low.
- R2: A program command (cmd_op 1 then cmd_op 3) aimed at an unlocked user word replaces that word with the old value ANDed with cmd_data, without raising prog_err.
- R3: A program command aimed at the identifier words leaves them unchanged and raises prog_err.
- R4: A lock command (cmd_op 2 then cmd_op 3) at address 080h clears the first-region lock only when cmd_data bit 1 is 0. The other data bits have no effect. The 080h status word carries the lock in bit 1, and all its other bits are 1.
- R5: While the first-region lock is 0, a program command to words 085h to 088h leaves them unchanged and raises prog_err. The second region stays writable.
- R6: A lock command at 089h ANDs cmd_data into the 16-bit lock word, and the 089h status returns that word. The second region refuses programs (unchanged, prog_err) only once the whole word is zero.
- R7: Once a lock is set, later lock commands cannot clear it again.
- R8: A data cycle (cmd_op 3) with no setup before it has no effect and raises no error. A setup is consumed by one data cycle. When two setups arrive in a row, the later one decides the operation.
- R9: A contents read (rd_en with rd_status low) while id_mode is low returns nothing (rd_valid stays low). A status query (rd_status high) is answered in any mode.
- R10: rd_valid and rd_data appear exactly one clock after an accepted read request.
- R11: A program aimed at an unmapped address, or a lock command aimed at any address other than the two lock addresses, changes nothing and raises prog_err. Unmapped addresses read FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command cycle present |
| cmd_op | input | 2 | 0 none, 1 program setup, 2 lock setup, 3 data |
| cmd_addr | input | ADDR_W | Word address of the data cycle |
| cmd_data | input | DATA_W | Data of the data cycle |
| id_mode | input | 1 | Identification mode enable for contents reads |
| rd_en | input | 1 | Read request |
| rd_status | input | 1 | Request is a lock status query (089h selects the second region, any other address the first) |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | Registered read data valid |
| prog_err | output | 1 | One-cycle flag for a refused data cycle |

## Verification
A data cycle changes storage on the same edge that samples it, and prog_err shows its verdict for the cycle after that edge. The bench therefore drives every input on the falling edge and reads prog_err on the falling edge that follows the data cycle. It then looks at the stored effect with a read issued no earlier than that, and it takes rd_data and rd_valid on the falling edge one clock after rd_en was driven. Refused or ignored commands are checked the same way, by reading back the targeted word or lock value.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    OP_NONE       = 2'd0,
    OP_PROG_SETUP = 2'd1,
    OP_LOCK_SETUP = 2'd2,
    OP_DATA       = 2'd3
  } prot_op_e;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_PROG = 2'd1,
    PD_LOCK = 2'd2
  } prot_pend_e;

  typedef enum logic [2:0] {
    RG_NONE, RG_LOCK0, RG_UID, RG_USR, RG_LOCK1, RG_R2
  } prot_rg_e;

  // Layout: lock0, identifier words, user words, lock1, second region.
  function automatic prot_rg_e prot_classify(input int a, input int l0,
                                             input int uid_n, input int usr_n,
                                             input int r2_n);
    int b_uid, b_usr, l1, b_r2;
    b_uid = l0 + 1;
    b_usr = b_uid + uid_n;
    l1    = b_usr + usr_n;
    b_r2  = l1 + 1;
    if (a == l0)                          return RG_LOCK0;
    else if (a >= b_uid && a < b_usr)     return RG_UID;
    else if (a >= b_usr && a < l1)        return RG_USR;
    else if (a == l1)                     return RG_LOCK1;
    else if (a >= b_r2 && a < b_r2 + r2_n) return RG_R2;
    else                                  return RG_NONE;
  endfunction

  function automatic int prot_offset(input int a, input int l0,
                                     input int uid_n, input int usr_n);
    prot_rg_e rg;
    rg = prot_classify(a, l0, uid_n, usr_n, 1 << 30);
    case (rg)
      RG_UID:  return a - (l0 + 1);
      RG_USR:  return a - (l0 + 1 + uid_n);
      RG_R2:   return a - (l0 + 2 + uid_n + usr_n);
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/prot_cmd_seq.sv
module prot_cmd_seq
  import prot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  prot_op_e cmd_op,
  output logic     prog_stb,
  output logic     lock_stb
);

  prot_pend_e pend_q;
  logic       data_cyc;

  always_comb begin
    data_cyc = cmd_valid && (cmd_op == OP_DATA);
    prog_stb = data_cyc && (pend_q == PD_PROG);
    lock_stb = data_cyc && (pend_q == PD_LOCK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PD_IDLE;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_PROG_SETUP: pend_q <= PD_PROG;
        OP_LOCK_SETUP: pend_q <= PD_LOCK;
        default:       pend_q <= PD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prot_store.sv
module prot_store
  import prot_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 9,
  parameter int LOCK0_ADDR = 'h080,
  parameter int UID_WORDS  = 4,
  parameter int USER_WORDS = 4,
  parameter int R2_WORDS   = 128,
  parameter logic [UID_WORDS*DATA_W-1:0] UID_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_stb,
  input  logic              lock_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] uid_o  [UID_WORDS],
  output logic [DATA_W-1:0] usr_o  [USER_WORDS],
  output logic [DATA_W-1:0] r2_o   [R2_WORDS],
  output logic              lock0_o,
  output logic [DATA_W-1:0] lock1_o,
  output logic              err_o
);

  localparam int USR_IW = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1;
  localparam int R2_IW  = (R2_WORDS > 1) ? $clog2(R2_WORDS) : 1;

  logic [DATA_W-1:0] uid_q [UID_WORDS];
  logic [DATA_W-1:0] usr_q [USER_WORDS];
  logic [DATA_W-1:0] r2_q  [R2_WORDS];
  logic              lock0_q;
  logic [DATA_W-1:0] lock1_q;
  logic              err_q;

  prot_rg_e          rg;
  int                off;
  logic [USR_IW-1:0] usr_idx;
  logic [R2_IW-1:0]  r2_idx;
  logic              usr_wr, r2_wr, prog_bad, lock_bad;

  always_comb begin
    rg       = prot_classify(int'(addr), LOCK0_ADDR, UID_WORDS, USER_WORDS, R2_WORDS);
    off      = prot_offset(int'(addr), LOCK0_ADDR, UID_WORDS, USER_WORDS);
    usr_idx  = USR_IW'(off);
    r2_idx   = R2_IW'(off);
    usr_wr   = prog_stb && (rg == RG_USR) && lock0_q;
    r2_wr    = prog_stb && (rg == RG_R2) && (|lock1_q);
    prog_bad = prog_stb && !usr_wr && !r2_wr;
    lock_bad = lock_stb && (rg != RG_LOCK0) && (rg != RG_LOCK1);
  end

  // Identifier: loaded at reset, no write path exists.
  for (genvar g = 0; g < UID_WORDS; g++) begin : g_uid
    always_ff @(posedge clk) begin
      if (rst) uid_q[g] <= UID_VALUE[g*DATA_W +: DATA_W];
    end
  end

  for (genvar g = 0; g < USER_WORDS; g++) begin : g_usr
    always_ff @(posedge clk) begin
      if (rst)
        usr_q[g] <= '1;
      else if (usr_wr && (usr_idx == USR_IW'(g)))
        usr_q[g] <= usr_q[g] & data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < R2_WORDS; i++) r2_q[i] <= '1;
    end else if (r2_wr) begin
      r2_q[r2_idx] <= r2_q[r2_idx] & data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock0_q <= 1'b1;
      lock1_q <= '1;
      err_q   <= 1'b0;
    end else begin
      err_q <= prog_bad || lock_bad;
      if (lock_stb && rg == RG_LOCK0) lock0_q <= lock0_q & data[1];
      if (lock_stb && rg == RG_LOCK1) lock1_q <= lock1_q & data;
    end
  end

  assign uid_o   = uid_q;
  assign usr_o   = usr_q;
  assign r2_o    = r2_q;
  assign lock0_o = lock0_q;
  assign lock1_o = lock1_q;
  assign err_o   = err_q;

endmodule

// File: rtl/prot_rd_port.sv
module prot_rd_port
  import prot_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 9,
  parameter int LOCK0_ADDR = 'h080,
  parameter int UID_WORDS  = 4,
  parameter int USER_WORDS = 4,
  parameter int R2_WORDS   = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_status,
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] uid_i  [UID_WORDS],
  input  logic [DATA_W-1:0] usr_i  [USER_WORDS],
  input  logic [DATA_W-1:0] r2_i   [R2_WORDS],
  input  logic              lock0_i,
  input  logic [DATA_W-1:0] lock1_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int UID_IW = (UID_WORDS > 1) ? $clog2(UID_WORDS) : 1;
  localparam int USR_IW = (USER_WORDS > 1) ? $clog2(USER_WORDS) : 1;
  localparam int R2_IW  = (R2_WORDS > 1) ? $clog2(R2_WORDS) : 1;

  prot_rg_e          rg;
  int                off;
  logic [DATA_W-1:0] st0, word;
  logic              fire;

  always_comb begin
    rg   = prot_classify(int'(rd_addr), LOCK0_ADDR, UID_WORDS, USER_WORDS, R2_WORDS);
    off  = prot_offset(int'(rd_addr), LOCK0_ADDR, UID_WORDS, USER_WORDS);
    st0  = '1;
    st0[1] = lock0_i;
    fire = rd_en && (rd_status || id_mode);
    if (rd_status) begin
      word = (rg == RG_LOCK1) ? lock1_i : st0;
    end else begin
      case (rg)
        RG_LOCK0: word = st0;
        RG_UID:   word = uid_i[UID_IW'(off)];
        RG_USR:   word = usr_i[USR_IW'(off)];
        RG_LOCK1: word = lock1_i;
        RG_R2:    word = r2_i[R2_IW'(off)];
        default:  word = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= fire;
      if (fire) rd_data <= word;
    end
  end

endmodule

// File: rtl/prot_reg_bank.sv
module prot_reg_bank
  import prot_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 9,
  parameter int LOCK0_ADDR = 'h080,
  parameter int UID_WORDS  = 4,
  parameter int USER_WORDS = 4,
  parameter int R2_WORDS   = 128,
  parameter logic [UID_WORDS*DATA_W-1:0] UID_VALUE = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              id_mode,
  input  logic              rd_en,
  input  logic              rd_status,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              prog_err
);

  prot_op_e          op_e;
  logic              prog_stb, lock_stb;
  logic [DATA_W-1:0] uid_w [UID_WORDS];
  logic [DATA_W-1:0] usr_w [USER_WORDS];
  logic [DATA_W-1:0] r2_w  [R2_WORDS];
  logic              lock0_q;
  logic [DATA_W-1:0] lock1_q;

  assign op_e = prot_op_e'(cmd_op);

  prot_cmd_seq u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(op_e),
    .prog_stb(prog_stb), .lock_stb(lock_stb)
  );

  prot_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK0_ADDR(LOCK0_ADDR),
    .UID_WORDS(UID_WORDS), .USER_WORDS(USER_WORDS), .R2_WORDS(R2_WORDS),
    .UID_VALUE(UID_VALUE)
  ) u_store (
    .clk(clk), .rst(rst), .prog_stb(prog_stb), .lock_stb(lock_stb),
    .addr(cmd_addr), .data(cmd_data),
    .uid_o(uid_w), .usr_o(usr_w), .r2_o(r2_w),
    .lock0_o(lock0_q), .lock1_o(lock1_q), .err_o(prog_err)
  );

  prot_rd_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK0_ADDR(LOCK0_ADDR),
    .UID_WORDS(UID_WORDS), .USER_WORDS(USER_WORDS), .R2_WORDS(R2_WORDS)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_status(rd_status),
    .id_mode(id_mode), .rd_addr(rd_addr),
    .uid_i(uid_w), .usr_i(usr_w), .r2_i(r2_w),
    .lock0_i(lock0_q), .lock1_i(lock1_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/prot_reg_bank_chk.sv
module prot_reg_bank_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              id_mode,
  input logic              rd_en,
  input logic              rd_status,
  input logic              rd_valid,
  input logic              prog_err,
  input logic              lock0,
  input logic [DATA_W-1:0] lock1
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R7: a cleared first-region lock stays cleared
  p_lock0_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !lock0 |=> !lock0);

  // R6: lock word bits never return to 1
  p_lock1_mono_r6: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((lock1 & ~$past(lock1)) == '0));

  // R4: the first-region lock only falls on a data cycle
  p_lock0_cause_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(lock0)) |-> $past(cmd_valid && cmd_op == 2'd3));

  // R10: an accepted read answers on the next cycle
  p_rd_answer_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (id_mode || rd_status)) |=> rd_valid);

  // R9: no answer without an accepted request
  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (id_mode || rd_status)) |=> !rd_valid);

  // R8: no error without a data cycle
  p_err_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_op == 2'd3) |=> !prog_err);

endmodule

bind prot_reg_bank prot_reg_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .id_mode(id_mode), .rd_en(rd_en), .rd_status(rd_status),
  .rd_valid(rd_valid), .prog_err(prog_err),
  .lock0(lock0_q), .lock1(lock1_q)
);

// File: tb/tb_prot_reg_bank.sv
module tb_prot_reg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [8:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        id_mode = 1'b1;
  logic        rd_en = 1'b0;
  logic        rd_status = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        prog_err;

  int nvec = 0;
  int nbad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prot_reg_bank dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode),
    .rd_en(rd_en), .rd_status(rd_status), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .prog_err(prog_err)
  );

  // {kind(2) 1=program 2=lock, status read(1), addr(9), data(16), err(1), read value(16)}
  localparam int NV = 17;
  localparam logic [44:0] VEC [NV] = '{
    {2'd1, 1'b0, 9'h085, 16'hFF0F, 1'b0, 16'hFF0F},  // R2
    {2'd1, 1'b0, 9'h085, 16'h0FFF, 1'b0, 16'h0F0F},  // R2
    {2'd1, 1'b0, 9'h08A, 16'h1234, 1'b0, 16'h1234},  // R2
    {2'd1, 1'b0, 9'h109, 16'h8001, 1'b0, 16'h8001},  // R2
    {2'd1, 1'b0, 9'h081, 16'h0000, 1'b1, 16'hCDEF},  // R3
    {2'd1, 1'b0, 9'h000, 16'h0000, 1'b1, 16'hFFFF},  // R11
    {2'd2, 1'b1, 9'h080, 16'h0002, 1'b0, 16'hFFFF},  // R4
    {2'd2, 1'b1, 9'h080, 16'hFFFD, 1'b0, 16'hFFFD},  // R4
    {2'd1, 1'b0, 9'h086, 16'h0000, 1'b1, 16'hFFFF},  // R5
    {2'd1, 1'b0, 9'h08B, 16'h00FF, 1'b0, 16'h00FF},  // R5
    {2'd2, 1'b1, 9'h089, 16'hFF00, 1'b0, 16'hFF00},  // R6
    {2'd1, 1'b0, 9'h08C, 16'h0F0F, 1'b0, 16'h0F0F},  // R6
    {2'd2, 1'b1, 9'h089, 16'h00FF, 1'b0, 16'h0000},  // R6
    {2'd1, 1'b0, 9'h08C, 16'h0000, 1'b1, 16'h0F0F},  // R6
    {2'd2, 1'b1, 9'h089, 16'hFFFF, 1'b0, 16'h0000},  // R7
    {2'd2, 1'b1, 9'h080, 16'hFFFF, 1'b0, 16'hFFFD},  // R7
    {2'd2, 1'b0, 9'h085, 16'h0000, 1'b1, 16'h0F0F}   // R11
  };

  function automatic string vreq(input int i);
    if (i < 4)       return "R2";
    else if (i == 4) return "R3";
    else if (i == 5) return "R11";
    else if (i < 8)  return "R4";
    else if (i < 10) return "R5";
    else if (i < 14) return "R6";
    else if (i < 16) return "R7";
    else             return "R11";
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [1:0] op, input logic [8:0] a,
                     input logic [15:0] d);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_data = d;
  endtask

  // Data cycle then idle; error flag is read on the idle cycle.
  task automatic data_then_idle(input logic [8:0] a, input logic [15:0] d,
                                output logic e);
    cyc(1'b1, 2'd3, a, d);
    cyc(1'b0, 2'd0, '0, '0);
    e = prog_err;
  endtask

  task automatic rd(input logic st, input logic [8:0] a,
                    output logic [15:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_status = st; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; rd_status = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    logic v, e;
    do_reset();

    // R8: data cycle without setup does nothing
    data_then_idle(9'h087, 16'h0000, e);
    chk("R8 bare data err", {15'b0, e}, 16'h0);
    rd(1'b0, 9'h087, d, v);
    chk("R8 bare data word", d, 16'hFFFF);
    cyc(1'b1, 2'd1, '0, '0);
    data_then_idle(9'h087, 16'hF0F0, e);
    chk("R8 setup+data err", {15'b0, e}, 16'h0);
    rd(1'b0, 9'h087, d, v);
    chk("R8 setup+data word", d, 16'hF0F0);
    data_then_idle(9'h087, 16'h0000, e);
    rd(1'b0, 9'h087, d, v);
    chk("R8 setup consumed", d, 16'hF0F0);
    cyc(1'b1, 2'd2, '0, '0);
    cyc(1'b1, 2'd1, '0, '0);
    data_then_idle(9'h087, 16'hFF00, e);
    rd(1'b0, 9'h087, d, v);
    chk("R8 later setup wins", d, 16'hF000);
    rd(1'b1, 9'h080, d, v);
    chk("R8 lock untouched", d, 16'hFFFF);

    // R9: contents need id_mode, status does not
    id_mode = 1'b0;
    rd(1'b0, 9'h081, d, v);
    chk("R9 no read outside id mode", {15'b0, v}, 16'h0);
    rd(1'b1, 9'h080, d, v);
    chk("R9 status valid", {15'b0, v}, 16'h1);
    chk("R9 status data", d, 16'hFFFF);
    id_mode = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [44:0] ent;
      ent = VEC[i];
      cyc(1'b1, ent[44:43], '0, '0);
      data_then_idle(ent[41:33], ent[32:17], e);
      chk({vreq(i), " err"}, {15'b0, e}, {15'b0, ent[16]});
      rd(ent[42], ent[41:33], d, v);
      chk("R10 valid", {15'b0, v}, 16'h1);
      chk({vreq(i), " read"}, d, ent[15:0]);
    end

    // R1: reset state
    do_reset();
    chk("R1 err", {15'b0, prog_err}, 16'h0);
    chk("R1 rd_valid", {15'b0, rd_valid}, 16'h0);
    rd(1'b0, 9'h081, d, v);  chk("R1 uid0", d, 16'hCDEF);
    rd(1'b0, 9'h082, d, v);  chk("R1 uid1", d, 16'h89AB);
    rd(1'b0, 9'h083, d, v);  chk("R1 uid2", d, 16'h4567);
    rd(1'b0, 9'h084, d, v);  chk("R1 uid3", d, 16'h0123);
    rd(1'b0, 9'h085, d, v);  chk("R1 user", d, 16'hFFFF);
    rd(1'b0, 9'h109, d, v);  chk("R1 region2 last", d, 16'hFFFF);
    rd(1'b1, 9'h080, d, v);  chk("R1 status0", d, 16'hFFFF);
    rd(1'b1, 9'h089, d, v);  chk("R1 status1", d, 16'hFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      nbad++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule